// File: doc/BRIEF.md
# USB Host Endpoint Schedule Scanner

This block keeps the endpoint schedule of a USB host controller and decides which endpoint is serviced next. Firmware builds or edits entries in a staging copy of the table through a plain word-write port. It then asks for a commit. At the next frame (or microframe) boundary, the staging copy is copied as a whole into the live copy. The scanner reads only the live copy, so a scan never sees a half-edited table.

On each frame tick the scanner walks the live copy from index 0. Entries below the periodic count form the periodic list (interrupt and isochronous endpoints). Entries from there up to the total count form the asynchronous list (bulk and control endpoints). An entry is skipped if it is halted. A periodic entry is also skipped if its polling countdown has not run out.

Each selected entry is offered on a valid/ready dispatch stream, with its index and decoded fields. Back-pressure rules:
- Once `disp_valid` rises, the index and every field stay frozen until `disp_ready` is seen high on a clock edge.
- The scanner moves to the next index only after that handshake.
- Holding `disp_ready` low stalls the walk indefinitely.
- `disp_valid` never depends combinationally on `disp_ready`.

Top module: `ep_sched_scan`

## Requirements
- R1: Each entry is three 32-bit words, numbered 0 to 2. The dispatch fields decode them as follows:
  - word 0: bits 4:0 endpoint number, bits 6:5 endpoint type, bit 9 halt, bits 13:10 NAK count, bits 15:14 error count, bit 16 isochronous flag, bits 31:24 start mask.
  - word 1: bits 10:0 maximum packet size, bits 18:11 polling rate.
  - word 2: bits 15:0 byte count, bit 16 transfer mode.
- R2: A write sets word `fw_wr_word` of entry `fw_wr_entry` in the staging copy only. A word number of 3 is ignored. Dispatch output is unaffected until a commit has been applied.
- R3: A commit request takes effect at the first frame start strictly after the request cycle. At that start the whole staging copy is copied into the live copy. A scan in progress keeps using the old live copy.
- R4: Within a frame, dispatches appear in strictly increasing index order over 0 up to (total count − 1). `disp_periodic` is 1 exactly for indices below the periodic count.
- R5: An entry whose halt bit (word 0 bit 9) is set is never dispatched.
- R6: Each periodic entry has a countdown.
  - At every frame start that applies no commit, a nonzero countdown drops by one.
  - A periodic entry is dispatched only when its countdown is zero.
  - On the dispatch handshake, the countdown reloads from the polling-rate field.
  - So a rate of R ≥ 1 gives one dispatch every R frames, and rates 0 and 1 both give one dispatch every frame.
- R7: A non-halted entry in the asynchronous list is dispatched once in every frame.
- R8: While `disp_valid` is high and `disp_ready` is low, `disp_valid`, `disp_idx` and all fields hold on the next cycle. Each handshake consumes exactly one entry.
- R9: A frame tick that arrives during a scan is held, and a new scan starts as soon as the current one ends. Several ticks during one scan yield a single extra scan.
- R10: After reset, `disp_valid` is low, both copies hold all-zero words and all countdowns are zero.
- R11: A frame start that applies a commit clears every countdown to zero.
- R12: The total count is clamped to the table size (32). The periodic count is clamped to the clamped total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_wr_en | input | 1 | Staging-copy write strobe |
| fw_wr_entry | input | 5 | Entry index to write |
| fw_wr_word | input | 2 | Word number within entry (0..2) |
| fw_wr_data | input | 32 | Write data |
| fw_commit | input | 1 | Request copy of staging table at next frame start |
| fw_per_cnt | input | 6 | Number of periodic entries, sampled at frame start |
| fw_tot_cnt | input | 6 | Periodic plus asynchronous entries, sampled at frame start |
| frame_tick | input | 1 | Frame or microframe boundary pulse |
| disp_valid | output | 1 | Dispatch entry available |
| disp_ready | input | 1 | Consumer accepts entry |
| disp_idx | output | 5 | Table index of dispatched entry |
| disp_periodic | output | 1 | Entry belongs to the periodic list |
| disp_ep_num | output | 5 | Endpoint number |
| disp_ep_type | output | 2 | Endpoint type |
| disp_iso | output | 1 | Isochronous flag |
| disp_nak_cnt | output | 4 | NAK count |
| disp_err_cnt | output | 2 | Error count |
| disp_smask | output | 8 | Start mask |
| disp_mps | output | 11 | Maximum packet size |
| disp_poll | output | 8 | Polling rate |
| disp_bytes | output | 16 | Total byte count |
| disp_mode | output | 1 | Transfer mode |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- **Commit landing mid-scan.** A design that swapped tables immediately would show new fields partway through a frame.
- **Ticks arriving while busy.** Dropping them would lose a frame, and counting each one would add extra scans.
- **Stalled consumer.** Random `disp_ready` gaps catch a scanner that advances or changes fields without a handshake.
- **Polling countdowns across many frames.** Random rates from 0 to 3 expose off-by-one reloads and a missing clear on commit.
- **Out-of-range counts.** Counts above 32, and a periodic count above the total, catch a design that walks past the table end or mislabels list membership.

// File: rtl/ep_sched_pkg.sv
package ep_sched_pkg;
  localparam int RATE_W = 8;

  typedef struct packed {
    logic [4:0]        ep_num;
    logic [1:0]        ep_type;
    logic              halt;
    logic [3:0]        nak_cnt;
    logic [1:0]        err_cnt;
    logic              iso;
    logic [7:0]        smask;
    logic [10:0]       mps;
    logic [RATE_W-1:0] poll;
    logic [15:0]       bytes;
    logic              mode;
  } ent_t;

  function automatic ent_t unpack_entry(input logic [31:0] w0, input logic [31:0] w1,
                                        input logic [31:0] w2);
    ent_t e;
    e.ep_num  = w0[4:0];
    e.ep_type = w0[6:5];
    e.halt    = w0[9];
    e.nak_cnt = w0[13:10];
    e.err_cnt = w0[15:14];
    e.iso     = w0[16];
    e.smask   = w0[31:24];
    e.mps     = w1[10:0];
    e.poll    = w1[18:11];
    e.bytes   = w2[15:0];
    e.mode    = w2[16];
    return e;
  endfunction
endpackage

// File: rtl/ep_table.sv
module ep_table #(
  parameter int N_ENT = 32,
  parameter int IDXW  = $clog2(N_ENT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_ent,
  input  logic [1:0]      wr_word,
  input  logic [31:0]     wr_data,
  input  logic            copy_en,
  input  logic [IDXW-1:0] rd_idx,
  output logic [31:0]     rd_w0,
  output logic [31:0]     rd_w1,
  output logic [31:0]     rd_w2
);
  localparam int WPE = 3;

  logic [31:0] stage [N_ENT][WPE];
  logic [31:0] live  [N_ENT][WPE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++)
        for (int w = 0; w < WPE; w++) begin
          stage[e][w] <= '0;
          live[e][w]  <= '0;
        end
    end else begin
      if (copy_en)
        for (int e = 0; e < N_ENT; e++)
          for (int w = 0; w < WPE; w++)
            live[e][w] <= stage[e][w];
      if (wr_en && (int'(wr_word) < WPE) && (int'(wr_ent) < N_ENT))
        stage[wr_ent][wr_word] <= wr_data;
    end
  end

  always_comb begin
    rd_w0 = '0;
    rd_w1 = '0;
    rd_w2 = '0;
    if (int'(rd_idx) < N_ENT) begin
      rd_w0 = live[rd_idx][0];
      rd_w1 = live[rd_idx][1];
      rd_w2 = live[rd_idx][2];
    end
  end
endmodule

// File: rtl/ep_rate_ctr.sv
module ep_rate_ctr #(
  parameter int N_ENT  = 32,
  parameter int IDXW   = $clog2(N_ENT),
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              dec,
  input  logic              reload_en,
  input  logic [IDXW-1:0]   reload_idx,
  input  logic [RATE_W-1:0] reload_val,
  input  logic [IDXW-1:0]   sel_idx,
  output logic              sel_zero
);
  logic [RATE_W-1:0] cnt [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        cnt[g] <= '0;
      else if (reload_en && (int'(reload_idx) == g))
        cnt[g] <= reload_val;
      else if (dec && (cnt[g] != '0))
        cnt[g] <= cnt[g] - 1'b1;
    end
  end

  assign sel_zero = (int'(sel_idx) < N_ENT) ? (cnt[sel_idx] == '0) : 1'b1;
endmodule

// File: rtl/ep_scan_fsm.sv
module ep_scan_fsm #(
  parameter int N_ENT = 32,
  parameter int CNTW  = $clog2(N_ENT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_tick,
  input  logic [CNTW-1:0] per_cnt,
  input  logic [CNTW-1:0] tot_cnt,
  input  logic            halt,
  input  logic            due,
  input  logic            ready,
  output logic            start,
  output logic [CNTW-1:0] idx,
  output logic            valid,
  output logic            periodic,
  output logic            reload,
  output logic [CNTW-1:0] per_lim,
  output logic [CNTW-1:0] tot_lim
);
  localparam logic [CNTW-1:0] NMAX = CNTW'(N_ENT);

  logic            busy, tick_pend, in_range, advance;
  logic [CNTW-1:0] tot_c, per_c;

  assign tot_c    = (tot_cnt > NMAX) ? NMAX : tot_cnt;
  assign per_c    = (per_cnt > tot_c) ? tot_c : per_cnt;
  assign start    = (frame_tick || tick_pend) && !busy;
  assign in_range = busy && (idx < tot_lim);
  assign periodic = idx < per_lim;
  assign valid    = in_range && !halt && (!periodic || due);
  assign advance  = in_range && (!valid || ready);
  assign reload   = valid && ready && periodic;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tick_pend <= 1'b0;
      idx       <= '0;
      per_lim   <= '0;
      tot_lim   <= '0;
    end else begin
      tick_pend <= start ? 1'b0 : (tick_pend || frame_tick);
      if (start) begin
        busy    <= 1'b1;
        idx     <= '0;
        tot_lim <= tot_c;
        per_lim <= per_c;
      end else if (busy) begin
        if (!in_range)    busy <= 1'b0;
        else if (advance) idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ep_sched_scan.sv
module ep_sched_scan #(
  parameter int N_ENT = 32,
  parameter int IDXW  = $clog2(N_ENT),
  parameter int CNTW  = $clog2(N_ENT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fw_wr_en,
  input  logic [IDXW-1:0] fw_wr_entry,
  input  logic [1:0]      fw_wr_word,
  input  logic [31:0]     fw_wr_data,
  input  logic            fw_commit,
  input  logic [CNTW-1:0] fw_per_cnt,
  input  logic [CNTW-1:0] fw_tot_cnt,
  input  logic            frame_tick,
  output logic            disp_valid,
  input  logic            disp_ready,
  output logic [IDXW-1:0] disp_idx,
  output logic            disp_periodic,
  output logic [4:0]      disp_ep_num,
  output logic [1:0]      disp_ep_type,
  output logic            disp_iso,
  output logic [3:0]      disp_nak_cnt,
  output logic [1:0]      disp_err_cnt,
  output logic [7:0]      disp_smask,
  output logic [10:0]     disp_mps,
  output logic [7:0]      disp_poll,
  output logic [15:0]     disp_bytes,
  output logic            disp_mode
);
  import ep_sched_pkg::*;

  logic            start, copy_en, commit_pend, sel_halt, cnt_zero, reload;
  logic [CNTW-1:0] scan_idx, per_lim, tot_lim;
  logic [31:0]     w0, w1, w2;
  ent_t            ent;

  assign copy_en = start && commit_pend;

  always_ff @(posedge clk) begin
    if (!rst_n)       commit_pend <= 1'b0;
    else if (copy_en) commit_pend <= fw_commit;
    else              commit_pend <= commit_pend || fw_commit;
  end

  ep_table #(.N_ENT(N_ENT), .IDXW(IDXW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(fw_wr_en), .wr_ent(fw_wr_entry),
    .wr_word(fw_wr_word), .wr_data(fw_wr_data), .copy_en(copy_en),
    .rd_idx(scan_idx[IDXW-1:0]), .rd_w0(w0), .rd_w1(w1), .rd_w2(w2)
  );

  assign ent      = unpack_entry(w0, w1, w2);
  assign sel_halt = ent.halt;

  ep_rate_ctr #(.N_ENT(N_ENT), .IDXW(IDXW), .RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .clear(copy_en), .dec(start && !commit_pend),
    .reload_en(reload), .reload_idx(scan_idx[IDXW-1:0]), .reload_val(ent.poll),
    .sel_idx(scan_idx[IDXW-1:0]), .sel_zero(cnt_zero)
  );

  ep_scan_fsm #(.N_ENT(N_ENT), .CNTW(CNTW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .per_cnt(fw_per_cnt),
    .tot_cnt(fw_tot_cnt), .halt(sel_halt), .due(cnt_zero), .ready(disp_ready),
    .start(start), .idx(scan_idx), .valid(disp_valid), .periodic(disp_periodic),
    .reload(reload), .per_lim(per_lim), .tot_lim(tot_lim)
  );

  assign disp_idx     = scan_idx[IDXW-1:0];
  assign disp_ep_num  = ent.ep_num;
  assign disp_ep_type = ent.ep_type;
  assign disp_iso     = ent.iso;
  assign disp_nak_cnt = ent.nak_cnt;
  assign disp_err_cnt = ent.err_cnt;
  assign disp_smask   = ent.smask;
  assign disp_mps     = ent.mps;
  assign disp_poll    = ent.poll;
  assign disp_bytes   = ent.bytes;
  assign disp_mode    = ent.mode;
endmodule

// File: rtl/ep_sched_scan_chk.sv
module ep_sched_scan_chk #(
  parameter int N_ENT = 32,
  parameter int IDXW  = $clog2(N_ENT),
  parameter int CNTW  = $clog2(N_ENT + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_valid,
  input logic            disp_ready,
  input logic [IDXW-1:0] disp_idx,
  input logic            disp_periodic,
  input logic [60:0]     disp_bus,
  input logic            sel_halt,
  input logic            cnt_zero,
  input logic [CNTW-1:0] per_lim,
  input logic [CNTW-1:0] tot_lim
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_idx) && $stable(disp_bus));

  p_no_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !sel_halt);

  p_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_periodic |-> cnt_zero);

  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> !disp_valid || (disp_idx > $past(disp_idx)));

  p_clamp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (per_lim <= tot_lim) && (int'(tot_lim) <= N_ENT));
endmodule

bind ep_sched_scan ep_sched_scan_chk #(.N_ENT(N_ENT), .IDXW(IDXW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_idx(disp_idx), .disp_periodic(disp_periodic),
  .disp_bus({disp_ep_num, disp_ep_type, disp_iso, disp_nak_cnt, disp_err_cnt, disp_smask,
             disp_mps, disp_poll, disp_bytes, disp_mode}),
  .sel_halt(sel_halt), .cnt_zero(cnt_zero), .per_lim(per_lim), .tot_lim(tot_lim)
);

// File: tb/tb_ep_sched_scan.sv
module tb_ep_sched_scan;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fw_wr_en = 1'b0, fw_commit = 1'b0, frame_tick = 1'b0, disp_ready = 1'b0;
  logic [4:0]  fw_wr_entry = '0;
  logic [1:0]  fw_wr_word = '0;
  logic [31:0] fw_wr_data = '0;
  logic [5:0]  fw_per_cnt = '0, fw_tot_cnt = '0;
  logic        disp_valid, disp_periodic, disp_iso, disp_mode;
  logic [4:0]  disp_idx, disp_ep_num;
  logic [1:0]  disp_ep_type, disp_err_cnt;
  logic [3:0]  disp_nak_cnt;
  logic [7:0]  disp_smask, disp_poll;
  logic [10:0] disp_mps;
  logic [15:0] disp_bytes;

  ep_sched_scan dut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  logic [31:0] m_sh [32][3];
  logic [31:0] m_act [32][3];
  int  m_cnt [32];
  bit  m_pend = 0;
  int  exp_q [$];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [60:0] exp_fields(input int i);
    logic [31:0] a, b, c;
    a = m_act[i][0]; b = m_act[i][1]; c = m_act[i][2];
    return {a[4:0], a[6:5], a[16], a[13:10], a[15:14], a[31:24], b[10:0], b[18:11],
            c[15:0], c[16]};
  endfunction

  function automatic void plan_frame();
    int t, p;
    if (m_pend) begin
      for (int e = 0; e < 32; e++) begin
        for (int w = 0; w < 3; w++) m_act[e][w] = m_sh[e][w];
        m_cnt[e] = 0;
      end
      m_pend = 0;
    end else begin
      for (int e = 0; e < 32; e++) if (m_cnt[e] > 0) m_cnt[e]--;
    end
    t = (fw_tot_cnt > 32) ? 32 : int'(fw_tot_cnt);
    p = (int'(fw_per_cnt) > t) ? t : int'(fw_per_cnt);
    for (int i = 0; i < t; i++) begin
      if (!m_act[i][0][9] && (i >= p || m_cnt[i] == 0)) begin
        exp_q.push_back(i + ((i < p) ? 256 : 0));
        if (i < p) m_cnt[i] = int'(m_act[i][1][18:11]);
      end
    end
  endfunction

  function automatic void check(input bit ok, input string what, input logic [63:0] act,
                                input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, expv);
    end
  endfunction

  task automatic fw_write(input int e, input int w, input logic [31:0] d);
    @(negedge clk);
    fw_wr_en = 1; fw_wr_entry = 5'(e); fw_wr_word = 2'(w); fw_wr_data = d;
    if (w < 3) m_sh[e][w] = d;
    @(negedge clk);
    fw_wr_en = 0;
  endtask

  task automatic run_frame(input bit extra_tick, input bit mid_commit, input int rdy_mode);
    logic [60:0] held_bus;
    logic [4:0]  held_idx;
    bit          hold = 0;
    int          v;
    @(negedge clk);
    frame_tick = 1;
    plan_frame();
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      frame_tick = 0;
      fw_commit  = 0;
      if (extra_tick && (c == 2 || c == 3)) begin
        frame_tick = 1;
        if (c == 2) plan_frame();  // R9: two ticks during a scan give one more scan
      end
      if (mid_commit && c == 5) begin
        fw_commit = 1;  // R3: applies only at the next frame start
        m_pend = 1;
      end
      if (hold) begin
        check(disp_valid && disp_idx == held_idx && disp_bus() == held_bus,
              "R8 hold under back-pressure", {disp_valid, disp_idx, disp_bus()},
              {1'b1, held_idx, held_bus});
      end
      disp_ready = (rdy_mode == 1) ? 1'b1 : (($urandom % 4) != 0);
      hold = 0;
      if (disp_valid) begin
        if (disp_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R4 R5 R6 unexpected dispatch", 64'(disp_idx), 64'hff);
          end else begin
            v = exp_q.pop_front();
            check(int'(disp_idx) == (v % 256) && disp_periodic == (v >= 256),
                  "R4 R5 R6 R7 R11 R12 index/list", {disp_periodic, disp_idx},
                  64'(v));
            check(disp_bus() == exp_fields(v % 256), "R1 R2 R3 fields", 64'(disp_bus()),
                  64'(exp_fields(v % 256)));
          end
        end else begin
          hold = 1; held_idx = disp_idx; held_bus = disp_bus();
        end
      end
    end
    disp_ready = 0;
    check(exp_q.size() == 0, "R5 R6 R7 R9 missing dispatches", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  function automatic logic [60:0] disp_bus();
    return {disp_ep_num, disp_ep_type, disp_iso, disp_nak_cnt, disp_err_cnt, disp_smask,
            disp_mps, disp_poll, disp_bytes, disp_mode};
  endfunction

  function automatic logic [31:0] rnd_w(input int w);
    logic [31:0] d;
    d = $urandom;
    if (w == 0) d[9] = (($urandom % 4) == 0);
    if (w == 1) d[18:11] = 8'($urandom % 4);
    return d;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int e = 0; e < 32; e++) begin
      for (int w = 0; w < 3; w++) begin m_sh[e][w] = '0; m_act[e][w] = '0; end
      m_cnt[e] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(disp_valid == 0, "R10 valid low after reset", 64'(disp_valid), 64'd0);
    // R10: zeroed table, all 32 asynchronous entries dispatch
    fw_tot_cnt = 6'd32; fw_per_cnt = 6'd0;
    run_frame(0, 0, 1);
    // R2: staging write without commit leaves dispatch fields unchanged
    fw_write(0, 0, 32'h1234_0003);
    fw_write(0, 3, 32'hffff_ffff);
    run_frame(0, 0, 1);
    // R6 / R11: periodic entries with rates, commit between frames
    fw_write(0, 1, 32'(3 << 11) | 32'd64);
    fw_write(1, 0, 32'h0000_0200);
    fw_write(2, 1, 32'(0 << 11));
    fw_per_cnt = 6'd3; fw_tot_cnt = 6'd6;
    m_pend = 1;
    @(negedge clk); fw_commit = 1; @(negedge clk); fw_commit = 0;
    for (int f = 0; f < 5; f++) run_frame(0, 0, 0);
    // R3: commit raised mid-scan with new staging data
    fw_write(3, 2, 32'h0001_abcd);
    run_frame(0, 1, 0);
    run_frame(0, 0, 0);
    // R9: two extra ticks during a busy scan
    fw_tot_cnt = 6'd20; fw_per_cnt = 6'd8;
    run_frame(1, 0, 0);
    // R12: counts out of range
    fw_tot_cnt = 6'd40; fw_per_cnt = 6'd50;
    run_frame(0, 0, 0);
    // random mix
    for (int f = 0; f < 30; f++) begin
      for (int k = 0; k < int'($urandom % 7); k++) begin
        int e, w;
        e = $urandom % 32; w = $urandom % 3;
        fw_write(e, w, rnd_w(w));
      end
      if (($urandom % 3) == 0) begin
        m_pend = 1;
        @(negedge clk); fw_commit = 1; @(negedge clk); fw_commit = 0;
      end
      if (($urandom % 4) == 0) begin
        fw_tot_cnt = 6'($urandom % 36);
        fw_per_cnt = 6'($urandom % (int'(fw_tot_cnt) + 3));
      end
      run_frame(fw_tot_cnt >= 6'd4 && ($urandom % 5) == 0, 0, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule